// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read and write strobes for parallel ATA programmed-I/O and multiword DMA cycles. Each attached device owns one packed 32-bit timing word. A cycle request names the device, the direction, whether it targets the data port or a task-file register, and whether it continues a burst. The block then runs a cycle with three parts. The first is an optional setup wait. The second holds the chosen strobe low for a counted number of clocks. The third holds it high for a counted recovery time. A one-clock done pulse then ends the cycle.

The timing words are loaded through a configuration port that replaces only the bits belonging to a transfer-mode class. A PIO mode update therefore leaves the DMA timing and enable bits alone, and the other classes behave the same way. A registered read-back output shows the stored word of the device addressed on the configuration port.

Top module: `pio_strobe_gen`

## Requirements
- R1: A synchronous active-high reset drives both strobes high, clears busy and done, and sets every stored timing word to zero (visible on the read-back output two clocks later), even when a cycle is in progress.
- R2: In a data cycle the strobe is low for (word[8:4] + 1) clocks. A read cycle uses rd_strobe_n and a write cycle uses wr_strobe_n, and the other strobe stays high for the whole cycle.
- R3: After the active part of a data cycle the strobe stays high for (word[3:0] + 1) clocks before done is raised.
- R4: A task-file (command) cycle instead takes its active time from word[17:13] + 1 and its recovery time from word[12:9] + 1.
- R5: A cycle that is not a continuation waits for a setup time after the start clock before the strobe goes low. The setup is word[24:22] clocks for data cycles and word[27:25] clocks for command cycles. A setup of zero puts the strobe low in the first clock after the start.
- R6: A cycle requested with the continuation flag set skips the setup time whatever the setup field holds.
- R7: Busy is high from the clock after an accepted start through the clock in which done is high. Done is high for exactly one clock, directly after the recovery time, and busy is low in the clock that follows it.
- R8: A start request made while busy is high is ignored. The running cycle keeps its timing and no further cycle follows it.
- R9: A configuration write replaces only the bits under the class mask: class 0 (PIO) 0xCFC3FFFF, class 1 (multiword DMA) 0x31C001FF, class 2 (Ultra DMA) 0x303C0000. Class 3 changes nothing. Only the addressed device's word changes, and bits 31:28 and 21:18 have no effect on strobe timing.
- R10: A cycle whose start falls in the same clock as a configuration write to its own device runs with the word held before that write.
- R11: Each cycle uses the timing word of the device selected at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Timing-word update strobe |
| cfg_dev | input | DEV_W | Device addressed by the update and the read-back |
| cfg_class | input | 2 | Mode class selecting the update mask |
| cfg_data | input | 32 | New timing bits |
| cfg_word_q | output | 32 | Registered stored word of cfg_dev |
| start | input | 1 | Cycle request |
| cyc_dev | input | DEV_W | Device whose word times the cycle |
| cyc_read | input | 1 | 1 for read, 0 for write |
| cyc_cmd | input | 1 | 1 for task-file cycle, 0 for data cycle |
| cyc_cont | input | 1 | Continuation of a burst: skip setup |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
Two functions can fall in the same clock: a timing-word update and the start of a cycle on the same device. The bench raises cfg_we and start on the same edge with a word that changes every timing field. It checks that the strobe pattern of that cycle matches the old word, and that the next cycle matches the new one. The second such pair is a new start raised during the done clock or in the middle of a cycle. The bench judges it by the unchanged done position and by busy staying low after the cycle ends.

// File: rtl/pio_tm_pkg.sv
package pio_tm_pkg;

  localparam int WORD_W    = 32;
  localparam int REC_W     = 4;
  localparam int ACT_W     = 5;
  localparam int SET_W     = 3;
  localparam int D_REC_LSB = 0;
  localparam int D_ACT_LSB = 4;
  localparam int C_REC_LSB = 9;
  localparam int C_ACT_LSB = 13;
  localparam int D_SET_LSB = 22;
  localparam int C_SET_LSB = 25;
  localparam int CNT_W     = ACT_W;

  localparam logic [WORD_W-1:0] MASK_PIO  = 32'hCFC3FFFF;
  localparam logic [WORD_W-1:0] MASK_MW   = 32'h31C001FF;
  localparam logic [WORD_W-1:0] MASK_UDMA = 32'h303C0000;

  typedef enum logic [1:0] {
    CLS_PIO  = 2'd0,
    CLS_MW   = 2'd1,
    CLS_UDMA = 2'd2,
    CLS_NONE = 2'd3
  } mode_cls_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACT,
    PH_REC,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [ACT_W-1:0] act;
    logic [REC_W-1:0] rec;
  } phase_cfg_t;

  function automatic logic [WORD_W-1:0] class_mask(mode_cls_e cls);
    case (cls)
      CLS_PIO:  return MASK_PIO;
      CLS_MW:   return MASK_MW;
      CLS_UDMA: return MASK_UDMA;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/pio_tw_store.sv
module pio_tw_store
  import pio_tm_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DEV_W = 1,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  wr_dev,
  input  mode_cls_e         wr_cls,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DEV_W-1:0]  sel_dev,
  output logic [WORD_W-1:0] sel_word,
  input  logic [DEV_W-1:0]  view_dev,
  output logic [WORD_W-1:0] view_word_q
);

  logic [WORD_W-1:0] words [NUM_DEV];
  logic [WORD_W-1:0] upd_mask;
  logic [WORD_W-1:0] view_c;

  assign upd_mask = class_mask(wr_cls);

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      always_ff @(posedge clk) begin
        if (rst) begin
          words[d] <= RESET_WORD;
        end else if (wr_en && wr_dev == DEV_W'(d)) begin
          words[d] <= (words[d] & ~upd_mask) | (wr_data & upd_mask);
        end
      end
    end
  endgenerate

  always_comb begin
    sel_word = RESET_WORD;
    view_c   = RESET_WORD;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (sel_dev == DEV_W'(d))  sel_word = words[d];
      if (view_dev == DEV_W'(d)) view_c   = words[d];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) view_word_q <= RESET_WORD;
    else     view_word_q <= view_c;
  end

endmodule

// File: rtl/pio_field_sel.sv
module pio_field_sel
  import pio_tm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              is_cmd,
  input  logic              cont,
  output phase_cfg_t        cfg
);

  logic [SET_W-1:0] setup_raw;
  logic             unused_bits;

  // Enable flags and Ultra DMA fields are stored only.
  assign unused_bits = ^{word[31:28], word[21:18]};

  always_comb begin
    if (is_cmd) begin
      setup_raw = word[C_SET_LSB +: SET_W];
      cfg.act   = word[C_ACT_LSB +: ACT_W];
      cfg.rec   = word[C_REC_LSB +: REC_W];
    end else begin
      setup_raw = word[D_SET_LSB +: SET_W];
      cfg.act   = word[D_ACT_LSB +: ACT_W];
      cfg.rec   = word[D_REC_LSB +: REC_W];
    end
    cfg.setup = cont ? '0 : setup_raw;
  end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_tm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_read,
  input  phase_cfg_t cfg,
  output logic       rd_n,
  output logic       wr_n,
  output logic       busy,
  output logic       done
);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [ACT_W-1:0] act_l;
  logic [REC_W-1:0] rec_l;
  logic             dir_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      act_l  <= '0;
      rec_l  <= '0;
      dir_rd <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          done <= 1'b0;
          if (start) begin
            busy   <= 1'b1;
            dir_rd <= is_read;
            act_l  <= cfg.act;
            rec_l  <= cfg.rec;
            if (cfg.setup != '0) begin
              ph  <= PH_SETUP;
              cnt <= CNT_W'(cfg.setup) - CNT_W'(1);
            end else begin
              ph   <= PH_ACT;
              cnt  <= CNT_W'(cfg.act);
              rd_n <= ~is_read;
              wr_n <= is_read;
            end
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ph   <= PH_ACT;
            cnt  <= CNT_W'(act_l);
            rd_n <= ~dir_rd;
            wr_n <= dir_rd;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_ACT: begin
          if (cnt == '0) begin
            ph   <= PH_REC;
            cnt  <= CNT_W'(rec_l);
            rd_n <= 1'b1;
            wr_n <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_REC: begin
          if (cnt == '0) begin
            ph   <= PH_DONE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_DONE: begin
          ph   <= PH_IDLE;
          done <= 1'b0;
          busy <= 1'b0;
        end
        default: begin
          ph   <= PH_IDLE;
          rd_n <= 1'b1;
          wr_n <= 1'b1;
          busy <= 1'b0;
          done <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_tm_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter logic [31:0] RESET_WORD = '0,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DEV_W-1:0] cfg_dev,
  input  logic [1:0]       cfg_class,
  input  logic [31:0]      cfg_data,
  output logic [31:0]      cfg_word_q,
  input  logic             start,
  input  logic [DEV_W-1:0] cyc_dev,
  input  logic             cyc_read,
  input  logic             cyc_cmd,
  input  logic             cyc_cont,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n,
  output logic             busy,
  output logic             done
);

  logic [WORD_W-1:0] cyc_word;
  phase_cfg_t        cyc_cfg;

  pio_tw_store #(
    .NUM_DEV(NUM_DEV),
    .DEV_W(DEV_W),
    .RESET_WORD(RESET_WORD)
  ) store_i (
    .clk(clk),
    .rst(rst),
    .wr_en(cfg_we),
    .wr_dev(cfg_dev),
    .wr_cls(mode_cls_e'(cfg_class)),
    .wr_data(cfg_data),
    .sel_dev(cyc_dev),
    .sel_word(cyc_word),
    .view_dev(cfg_dev),
    .view_word_q(cfg_word_q)
  );

  pio_field_sel sel_i (
    .word(cyc_word),
    .is_cmd(cyc_cmd),
    .cont(cyc_cont),
    .cfg(cyc_cfg)
  );

  pio_phase_seq seq_i (
    .clk(clk),
    .rst(rst),
    .start(start),
    .is_read(cyc_read),
    .cfg(cyc_cfg),
    .rd_n(rd_strobe_n),
    .wr_n(wr_strobe_n),
    .busy(busy),
    .done(done)
  );

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rd_strobe_n,
  input logic wr_strobe_n,
  input logic busy,
  input logic done
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (rd_strobe_n && wr_strobe_n && !busy && !done));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_n || wr_strobe_n));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_busy_drops: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe_n || !wr_strobe_n) |-> busy);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  a_r7_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

endmodule

bind pio_strobe_gen pio_strobe_chk chk_i (
  .clk(clk),
  .rst(rst),
  .start(start),
  .rd_strobe_n(rd_strobe_n),
  .wr_strobe_n(wr_strobe_n),
  .busy(busy),
  .done(done)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [0:0]  cfg_dev;
  logic [1:0]  cfg_class;
  logic [31:0] cfg_data;
  logic [31:0] cfg_word_q;
  logic        start;
  logic [0:0]  cyc_dev;
  logic        cyc_read;
  logic        cyc_cmd;
  logic        cyc_cont;
  logic        rd_strobe_n;
  logic        wr_strobe_n;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [2];

  always #5 clk = ~clk;

  pio_strobe_gen dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_class(cfg_class),
    .cfg_data(cfg_data), .cfg_word_q(cfg_word_q),
    .start(start), .cyc_dev(cyc_dev), .cyc_read(cyc_read),
    .cyc_cmd(cyc_cmd), .cyc_cont(cyc_cont),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .busy(busy), .done(done)
  );

  function automatic logic [31:0] f_mask(input logic [1:0] cls);
    case (cls)
      2'd0: return 32'hCFC3FFFF;
      2'd1: return 32'h31C001FF;
      2'd2: return 32'h303C0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int f_setup(input logic [31:0] w, input logic cmd, input logic cont);
    if (cont) return 0;
    return cmd ? int'(w[27:25]) : int'(w[24:22]);
  endfunction

  function automatic int f_act(input logic [31:0] w, input logic cmd);
    return cmd ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
  endfunction

  function automatic int f_rec(input logic [31:0] w, input logic cmd);
    return cmd ? int'(w[12:9]) + 1 : int'(w[3:0]) + 1;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input logic dev, input logic [1:0] cls, input logic [31:0] d);
    cfg_we = 1'b1; cfg_dev = dev; cfg_class = cls; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model[dev] = (model[dev] & ~f_mask(cls)) | (d & f_mask(cls));
    @(negedge clk);
    check("R9 stored word", cfg_word_q, model[dev]);
  endtask

  // Runs one cycle; optional same-clock config write and mid-cycle ignored start.
  task automatic run_cyc(input logic dev, input logic rd, input logic cmd, input logic cont,
                         input bit poke, input bit wr_same, input logic [1:0] wcls,
                         input logic [31:0] wdat, input string tag);
    int s, a, r, first_low, low_cnt, done_k, done_cnt, busy_bad, other_low, tot;
    s = f_setup(model[dev], cmd, cont);
    a = f_act(model[dev], cmd);
    r = f_rec(model[dev], cmd);
    tot = s + a + r + 1;
    first_low = 0; low_cnt = 0; done_k = 0; done_cnt = 0; busy_bad = 0; other_low = 0;
    start = 1'b1; cyc_dev = dev; cyc_read = rd; cyc_cmd = cmd; cyc_cont = cont;
    if (wr_same) begin
      cfg_we = 1'b1; cfg_dev = dev; cfg_class = wcls; cfg_data = wdat;
    end
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    if (wr_same) model[dev] = (model[dev] & ~f_mask(wcls)) | (wdat & f_mask(wcls));
    for (int k = 1; k <= tot + 3; k++) begin
      logic sel_n, oth_n;
      sel_n = rd ? rd_strobe_n : wr_strobe_n;
      oth_n = rd ? wr_strobe_n : rd_strobe_n;
      if (!sel_n) begin low_cnt++; if (first_low == 0) first_low = k; end
      if (!oth_n) other_low++;
      if (done) begin done_cnt++; if (done_k == 0) done_k = k; end
      if ((k <= tot) != busy) busy_bad++;
      if (poke && (k == 2 || k == tot)) begin
        start = 1'b1; cyc_read = ~rd; cyc_cmd = ~cmd; cyc_cont = 1'b0; cyc_dev = ~dev;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check({tag, " R5/R6 first low clock"}, first_low, s + 1);
    check({tag, " active clocks"}, low_cnt, a);
    check("R2 other strobe stays high", other_low, 0);
    check("R3 done position after recovery", done_k, tot);
    check("R7 done count", done_cnt, 1);
    check("R7 busy window", busy_bad, 0);
    if (poke) check("R8 no extra cycle", done_cnt + busy_bad, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED);
    rst = 1'b1; cfg_we = 1'b0; cfg_dev = '0; cfg_class = '0; cfg_data = '0;
    start = 1'b0; cyc_dev = '0; cyc_read = 1'b0; cyc_cmd = 1'b0; cyc_cont = 1'b0;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset strobes", {rd_strobe_n, wr_strobe_n}, 2'b11);
    check("R1 reset busy/done", {busy, done}, 2'b00);
    check("R1 reset word", cfg_word_q, 32'h0);

    // R2 R3: reset word gives single-clock phases
    run_cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 2'd0, 32'h0, "R2 data read zero word");
    // R5: large setup and times, data write then R4 command
    do_cfg(1'b0, 2'd0, 32'hFFFF_FFFF);
    run_cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 2'd0, 32'h0, "R2 data write max");
    run_cyc(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 2'd0, 32'h0, "R4 cmd read max");
    // R6: continuation skips setup
    run_cyc(1'b0, 1'b1, 1'b1, 1'b1, 0, 0, 2'd0, 32'h0, "R6 cmd cont");
    run_cyc(1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 2'd0, 32'h0, "R6 data cont");
    // R9: class 3 changes nothing, UDMA and MW masks, other device untouched
    do_cfg(1'b0, 2'd3, 32'h0);
    do_cfg(1'b0, 2'd2, 32'h0);
    do_cfg(1'b0, 2'd1, 32'h1234_5678);
    cfg_dev = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 other device untouched", cfg_word_q, model[1]);
    // R11: device 1 has its own word
    do_cfg(1'b1, 2'd0, 32'h0A81_F442);
    run_cyc(1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 2'd0, 32'h0, "R11 dev1 data");
    run_cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 2'd0, 32'h0, "R11 dev0 data");
    // R8: start pulses mid-cycle and in the done clock
    run_cyc(1'b1, 1'b0, 1'b1, 1'b0, 1, 0, 2'd0, 32'h0, "R8 poke cmd");
    // R10: config write in the same clock as start
    run_cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 2'd0, 32'h0C82_9C62, "R10 old word");
    run_cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 2'd0, 32'h0, "R10 new word");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic dv;
      dv = 1'($urandom);
      if ($urandom % 3 == 0) do_cfg(dv, 2'($urandom), $urandom);
      run_cyc(dv, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 == 0),
              ($urandom % 5 == 0), 2'($urandom), $urandom, "R2 random");
    end

    // R1: reset during the active part
    do_cfg(1'b0, 2'd0, 32'hFFFF_FFFF);
    start = 1'b1; cyc_dev = 1'b0; cyc_read = 1'b1; cyc_cmd = 1'b0; cyc_cont = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 strobe low before reset", rd_strobe_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-cycle reset strobes", {rd_strobe_n, wr_strobe_n}, 2'b11);
    check("R1 mid-cycle reset busy/done", {busy, done}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    model[0] = '0; model[1] = '0;
    cfg_dev = 1'b0;
    @(negedge clk);
    check("R1 word cleared", cfg_word_q, 32'h0);
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {busy, rd_strobe_n, wr_strobe_n}, 3'b011);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule